// File: doc/BRIEF.md
# Delayed Sweep Gate Controller

This block sequences a main sweep and a delayed sweep in a digitized display timebase. A main trigger starts the main sweep, modelled as a ramp counter that climbs from zero to a fixed end value. At that start the controller captures which of two delay reference values applies, together with the delayed-sweep start mode and length. The ramp is compared against the captured reference. When the ramp reaches it, an active-low delay gate asserts, and that arms the delayed-sweep start path.

The delayed sweep has two start modes. In run-after-delay mode it starts on the same clock edge as the delay gate. In triggered-after-delay mode it waits for a delayed-trigger pulse that arrives once the delay gate is already low. The start appears on an active-low start gate. A delayed-sweep-active gate then runs for a programmable number of cycles, or until the main sweep ends, whichever comes first. When the main ramp reaches its end value, every gate is released on the same edge and the controller waits for the next main trigger.

Top module: `dly_sweep_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, `dgate_n` and `bstart_n` are 1 and `main_gate` and `dly_gate` are 0.
- R2: If `main_trig` is high at an edge while the controller is idle, `main_gate` is 1 from that edge onward and the ramp restarts at 0. A `main_trig` seen while `main_gate` is 1 has no effect on any output.
- R3: `main_gate` stays high for exactly MAIN_END+1 cycles. On the edge that ends it, `dgate_n`, `bstart_n` and `dly_gate` return to their idle values.
- R4: At main-sweep start, `ref_sel`=0 selects `ref_a` and `ref_sel`=1 selects `ref_b`. The selected value, `dly_mode` and `dly_len` are captured at that edge. Later changes to them have no effect until the next start.
- R5: `dgate_n` goes to 0 one cycle after the ramp equals the captured reference (that is, ref+1 cycles after `main_gate` rises) and stays low until the main sweep ends. A reference of MAIN_END or more never asserts it.
- R6: With `dly_mode`=1 (run after delay), `bstart_n` falls on the same edge as `dgate_n`.
- R7: With `dly_mode`=0 (triggered after delay), `bstart_n` falls on the edge that samples `dly_trig` high while `dgate_n` is already 0 and the main sweep is not ending. Once low, it stays low until the main sweep ends.
- R8: `dly_trig` has no effect while idle, and none while `dgate_n` is still 1. This includes a pulse sampled on the very edge where `dgate_n` falls.
- R9: `dly_gate` rises with the fall of `bstart_n` and stays high for `dly_len` cycles (a length of 0 acts as 1), or until the main sweep ends. It starts at most once per main sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| main_trig | input | 1 | Main sweep trigger |
| ref_sel | input | 1 | Delay reference select (0: ref_a, 1: ref_b) |
| ref_a | input | RAMP_W | Delay reference 0 |
| ref_b | input | RAMP_W | Delay reference 1 |
| dly_mode | input | 1 | 0: triggered after delay, 1: run after delay |
| dly_len | input | RAMP_W | Delayed sweep length in cycles |
| dly_trig | input | 1 | Delayed trigger event |
| dgate_n | output | 1 | Delay gate, active low |
| bstart_n | output | 1 | Delayed sweep start gate, active low |
| main_gate | output | 1 | Main sweep active |
| dly_gate | output | 1 | Delayed sweep active |

## Verification
Every output is registered, so each result is due one edge after the input or ramp value that causes it. With the start edge counted as index 0, `main_gate` is high for indices 0 to MAIN_END, and `dgate_n` falls at index ref+1. `bstart_n` falls at index ref+1 in run mode, or at t+1 for a qualifying trigger pulse that was driven after index t. `dly_gate` covers that start index through start+len-1, cut off at MAIN_END. The bench drives inputs and samples outputs on the falling edge, and compares all four outputs with these per-index expectations every cycle of every sweep and of the idle gaps.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic {
    MODE_TRIG_AFTER = 1'b0,
    MODE_RUN_AFTER  = 1'b1
  } dmode_e;
endpackage

// File: rtl/dsc_main_ramp.sv
module dsc_main_ramp
  import dsc_pkg::*;
#(
  parameter int RAMP_W   = 8,
  parameter int MAIN_END = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic              ref_sel,
  input  logic [RAMP_W-1:0] ref_a,
  input  logic [RAMP_W-1:0] ref_b,
  input  logic              mode_in,
  input  logic [RAMP_W-1:0] len_in,
  output logic              main_gate,
  output logic [RAMP_W-1:0] cnt,
  output logic              at_end,
  output logic [RAMP_W-1:0] ref_l,
  output dmode_e            mode_l,
  output logic [RAMP_W-1:0] len_l
);
  localparam logic [RAMP_W-1:0] END_V = RAMP_W'(MAIN_END);

  assign at_end = main_gate && (cnt == END_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      main_gate <= 1'b0;
      cnt       <= '0;
      ref_l     <= '0;
      mode_l    <= MODE_TRIG_AFTER;
      len_l     <= '0;
    end else if (!main_gate) begin
      if (trig) begin
        main_gate <= 1'b1;
        cnt       <= '0;
        ref_l     <= ref_sel ? ref_b : ref_a;
        mode_l    <= dmode_e'(mode_in);
        len_l     <= len_in;
      end
    end else if (at_end) begin
      main_gate <= 1'b0;
      cnt       <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_ramp_bound_R3: assert property (@(posedge clk) disable iff (rst)
    main_gate |-> (cnt <= END_V));
  assert_end_clears_R3: assert property (@(posedge clk) disable iff (rst)
    at_end |=> !main_gate);
  assert_cfg_held_R4: assert property (@(posedge clk) disable iff (rst)
    (main_gate && $past(main_gate)) |-> ($stable(ref_l) && $stable(len_l) && $stable(mode_l)));
endmodule

// File: rtl/dsc_delay_cmp.sv
module dsc_delay_cmp #(
  parameter int RAMP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              main_gate,
  input  logic              at_end,
  input  logic [RAMP_W-1:0] cnt,
  input  logic [RAMP_W-1:0] ref_l,
  output logic              dgate_n,
  output logic              hit
);
  assign hit = main_gate && !at_end && dgate_n && (cnt == ref_l);

  always_ff @(posedge clk) begin
    if (rst) begin
      dgate_n <= 1'b1;
    end else if (!main_gate || at_end) begin
      dgate_n <= 1'b1;
    end else if (hit) begin
      dgate_n <= 1'b0;
    end
  end

  assert_dgate_in_sweep_R5: assert property (@(posedge clk) disable iff (rst)
    !dgate_n |-> main_gate);
  assert_dgate_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (!dgate_n && !at_end) |=> !dgate_n);
endmodule

// File: rtl/dsc_dly_sweep.sv
module dsc_dly_sweep
  import dsc_pkg::*;
#(
  parameter int RAMP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              main_gate,
  input  logic              at_end,
  input  logic              dgate_n,
  input  logic              hit,
  input  dmode_e            mode_l,
  input  logic [RAMP_W-1:0] len_l,
  input  logic              dly_trig,
  output logic              bstart_n,
  output logic              dly_gate
);
  logic [RAMP_W-1:0] bcnt;
  logic              run_go, trig_go, start;

  assign run_go  = (mode_l == MODE_RUN_AFTER) && hit;
  assign trig_go = (mode_l == MODE_TRIG_AFTER) && !dgate_n && dly_trig;
  assign start   = main_gate && !at_end && bstart_n && (run_go || trig_go);

  always_ff @(posedge clk) begin
    if (rst) begin
      bstart_n <= 1'b1;
      dly_gate <= 1'b0;
      bcnt     <= '0;
    end else if (!main_gate || at_end) begin
      bstart_n <= 1'b1;
      dly_gate <= 1'b0;
      bcnt     <= '0;
    end else if (start) begin
      bstart_n <= 1'b0;
      dly_gate <= 1'b1;
      bcnt     <= RAMP_W'(1);
    end else if (dly_gate) begin
      if (bcnt >= len_l) dly_gate <= 1'b0;
      else               bcnt     <= bcnt + 1'b1;
    end
  end

  assert_bstart_needs_dgate_R7: assert property (@(posedge clk) disable iff (rst)
    !bstart_n |-> !dgate_n);
  assert_run_start_R6: assert property (@(posedge clk) disable iff (rst)
    ((mode_l == MODE_RUN_AFTER) && $fell(dgate_n)) |-> $fell(bstart_n));
  assert_dly_gate_inside_R9: assert property (@(posedge clk) disable iff (rst)
    dly_gate |-> (main_gate && !bstart_n));
  assert_single_start_R9: assert property (@(posedge clk) disable iff (rst)
    (!bstart_n && !dly_gate) |=> !dly_gate);
endmodule

// File: rtl/dly_sweep_ctrl.sv
module dly_sweep_ctrl
  import dsc_pkg::*;
#(
  parameter int RAMP_W   = 8,
  parameter int MAIN_END = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              main_trig,
  input  logic              ref_sel,
  input  logic [RAMP_W-1:0] ref_a,
  input  logic [RAMP_W-1:0] ref_b,
  input  logic              dly_mode,
  input  logic [RAMP_W-1:0] dly_len,
  input  logic              dly_trig,
  output logic              dgate_n,
  output logic              bstart_n,
  output logic              main_gate,
  output logic              dly_gate
);
  logic [RAMP_W-1:0] cnt, ref_l, len_l;
  logic              at_end, hit;
  dmode_e            mode_l;

  dsc_main_ramp #(.RAMP_W(RAMP_W), .MAIN_END(MAIN_END)) u_ramp (
    .clk(clk), .rst(rst), .trig(main_trig), .ref_sel(ref_sel),
    .ref_a(ref_a), .ref_b(ref_b), .mode_in(dly_mode), .len_in(dly_len),
    .main_gate(main_gate), .cnt(cnt), .at_end(at_end),
    .ref_l(ref_l), .mode_l(mode_l), .len_l(len_l)
  );

  dsc_delay_cmp #(.RAMP_W(RAMP_W)) u_cmp (
    .clk(clk), .rst(rst), .main_gate(main_gate), .at_end(at_end),
    .cnt(cnt), .ref_l(ref_l), .dgate_n(dgate_n), .hit(hit)
  );

  dsc_dly_sweep #(.RAMP_W(RAMP_W)) u_dly (
    .clk(clk), .rst(rst), .main_gate(main_gate), .at_end(at_end),
    .dgate_n(dgate_n), .hit(hit), .mode_l(mode_l), .len_l(len_l),
    .dly_trig(dly_trig), .bstart_n(bstart_n), .dly_gate(dly_gate)
  );

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !main_gate |-> (dgate_n && bstart_n && !dly_gate));
endmodule

// File: tb/dly_sweep_ctrl_bench.sv
module dly_sweep_ctrl_bench;
  localparam int RAMP_W   = 8;
  localparam int MAIN_END = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic main_trig = 1'b0, ref_sel = 1'b0, dly_mode = 1'b0, dly_trig = 1'b0;
  logic [RAMP_W-1:0] ref_a = '0, ref_b = '0, dly_len = '0;
  logic dgate_n, bstart_n, main_gate, dly_gate;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dly_sweep_ctrl #(.RAMP_W(RAMP_W), .MAIN_END(MAIN_END)) u_dly_sweep_ctrl (
    .clk(clk), .rst(rst), .main_trig(main_trig), .ref_sel(ref_sel),
    .ref_a(ref_a), .ref_b(ref_b), .dly_mode(dly_mode), .dly_len(dly_len),
    .dly_trig(dly_trig), .dgate_n(dgate_n), .bstart_n(bstart_n),
    .main_gate(main_gate), .dly_gate(dly_gate)
  );

  task automatic chk(input string tag, input logic act, input logic exp, input int idx);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s idx=%0d actual=%b expected=%b", tag, idx, act, exp);
    end
  endtask

  // Index at which the delayed sweep starts, or -1.
  function automatic int start_idx(int rf, bit mode, int t1, int t2);
    int s = -1;
    if (rf >= MAIN_END) return -1;
    if (mode) return rf + 1;
    if (t1 >= rf + 1 && t1 <= MAIN_END - 1) s = t1 + 1;
    if (t2 >= rf + 1 && t2 <= MAIN_END - 1 && (s < 0 || t2 + 1 < s)) s = t2 + 1;
    return s;
  endfunction

  task automatic check_idle(input int idx);
    chk("R1/R3 idle dgate_n", dgate_n, 1'b1, idx);
    chk("R1/R3 idle bstart_n", bstart_n, 1'b1, idx);
    chk("R1/R2 idle main_gate", main_gate, 1'b0, idx);
    chk("R1/R3 idle dly_gate", dly_gate, 1'b0, idx);
  endtask

  // One full sweep. t1/t2: delayed-trigger pulse indices (-1 none);
  // tm: index of an extra main trigger during the sweep (-1 none).
  task automatic run_sweep(input bit sel, input int ra, input int rb, input bit mode,
                           input int len, input int t1, input int t2, input int tm,
                           input int gap);
    int rf, s, l, dend;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      check_idle(-1);
      dly_trig = (g == 0);  // idle delayed trigger must do nothing (R8)
    end
    @(negedge clk);
    dly_trig = 1'b0;
    main_trig = 1'b1;
    ref_sel = sel; ref_a = RAMP_W'(ra); ref_b = RAMP_W'(rb);
    dly_mode = mode; dly_len = RAMP_W'(len);
    rf = sel ? rb : ra;
    s = start_idx(rf, mode, t1, t2);
    l = (len == 0) ? 1 : len;
    dend = (s + l - 1 > MAIN_END) ? MAIN_END : s + l - 1;
    for (int j = 0; j <= MAIN_END + 1; j++) begin
      @(negedge clk);
      chk("R2/R3 main_gate", main_gate, (j <= MAIN_END), j);
      chk("R4/R5 dgate_n", dgate_n,
          !(rf < MAIN_END && j >= rf + 1 && j <= MAIN_END), j);
      chk(mode ? "R6 bstart_n" : "R7/R8 bstart_n", bstart_n,
          !(s >= 0 && j >= s && j <= MAIN_END), j);
      chk("R9 dly_gate", dly_gate, (s >= 0 && j >= s && j <= dend), j);
      // disturb inputs to show the start-time capture (R4)
      main_trig = (j == tm);
      dly_trig  = (j == t1) || (j == t2);
      ref_sel = ~sel; ref_a = ~RAMP_W'(ra); ref_b = ~RAMP_W'(rb);
      dly_mode = ~mode; dly_len = RAMP_W'(len + 7);
    end
    main_trig = 1'b0;
    dly_trig = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int ra, rb, t1, t2, tm;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check_idle(-2);  // R1 during reset
    rst = 1'b0;
    @(negedge clk);
    check_idle(-3);  // R1 first cycle after reset

    // Directed corner cases
    run_sweep(1'b0, 0, 50, 1'b1, 5, -1, -1, -1, 2);          // ref 0, run mode, R6
    run_sweep(1'b1, 9, 30, 1'b0, 4, 30, 45, 100, 3);         // ref_b, trig on dgate edge ignored, R8
    run_sweep(1'b0, 40, 0, 1'b0, 10, 10, 60, -1, 1);         // early trig ignored R8, late starts R7
    run_sweep(1'b0, MAIN_END - 1, 0, 1'b1, 9, -1, -1, -1, 1);// start on last index, R9 cut
    run_sweep(1'b1, 0, MAIN_END, 1'b1, 3, -1, -1, -1, 1);    // ref == end never R5
    run_sweep(1'b0, 250, 0, 1'b0, 3, 100, -1, -1, 1);        // ref beyond end R5
    run_sweep(1'b0, 20, 0, 1'b0, 0, MAIN_END - 1, -1, -1, 1);// trig at end-1, len 0 as 1
    run_sweep(1'b0, 20, 0, 1'b0, 5, MAIN_END, -1, -1, 1);    // trig on end edge ignored R7
    run_sweep(1'b1, 0, 100, 1'b1, 255, -1, -1, 150, 1);      // long len cut by end R3/R9

    // Constrained random sweeps
    for (int n = 0; n < 40; n++) begin
      ra = int'($urandom_range(0, 230));
      rb = int'($urandom_range(0, 230));
      t1 = int'($urandom_range(0, MAIN_END + 1));
      t2 = ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, MAIN_END)) : -1;
      tm = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, MAIN_END)) : -1;
      run_sweep(1'($urandom_range(0, 1)), ra, rb, 1'($urandom_range(0, 1)),
                int'($urandom_range(0, 80)), t1, t2, tm,
                int'($urandom_range(1, 6)));
    end

    @(negedge clk);
    check_idle(-4);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule